// File: doc/BRIEF.md
# Hiccup Fault Restart Sequencer

This block is the digital fault sequencer of a synchronous buck controller. It takes four fault indications from external comparators: bias-supply undervoltage, input-supply undervoltage, over-temperature and output short circuit. Each flag is resynchronised, and the block then decides when the power stage may switch. While any fault is visible, the gate drivers are held off and the soft-start and compensation nodes are clamped low. The block then follows a restart policy chosen by the fault class, and always restarts through a fresh soft-start ramp.

An undervoltage fault simply holds the block idle until the flag drops. A short circuit starts a hiccup delay, and a soft-start is attempted when that delay ends. An over-temperature fault starts the same delay, but the delay keeps repeating while the flag remains set. The delay is counted in ticks of an external timebase, so a short count can be used for simulation. A ready output reports regulation once soft-start has finished and no fault is pending.

Top module: `hiccup_restart_seq`

## Requirements
- R1: During reset and on the first cycles after it, `drv_off` and `ss_clamp` are 1 and `ready` is 0. The undervoltage synchroniser stages reset to "fault present", so soft-start begins on the third clock edge after reset is released, provided all flags are clear.
- R2: Each raw fault flag passes through two flip-flops. A raw flag set before clock edge k is seen by the outputs just after edge k+1.
- R3: In the cycle in which a synchronised fault first becomes visible, `drv_off` and `ss_clamp` go to 1 and `ready` goes to 0, without waiting for the state register.
- R4: While either undervoltage flag is set, the block stays idle for any length of time. Once the synchronised flag clears, soft-start is entered on the next edge, with no delay timer.
- R5: A short circuit enters a hiccup delay of HICCUP_TICKS timebase ticks. Soft-start is re-entered on the edge at which the delay ends, even if the short is still present.
- R6: An over-temperature fault enters the same delay. At each expiry the delay reloads if the flag is still set. Soft-start is entered only at the first expiry that finds the flag clear.
- R7: When faults occur together, undervoltage is served before over-temperature, and over-temperature before short circuit.
- R8: A short circuit that appears during soft-start is detected and handled exactly as one that appears during regulation.
- R9: Every restart passes through soft-start, during which `ready` is 0. `ready` rises on the edge after `ss_done` is seen high in soft-start.
- R10: The hiccup delay advances only on clock edges where `tick` is 1. With `tick` held at 0, the block stays in the delay indefinitely.
- R11: An over-temperature flag arriving during a short-circuit delay restarts the delay and applies the over-temperature rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Timebase pulse that advances the hiccup delay |
| uv_bias | input | 1 | Raw bias-supply undervoltage flag, 1 = fault |
| uv_input | input | 1 | Raw input-supply undervoltage flag, 1 = fault |
| over_temp | input | 1 | Raw over-temperature flag, 1 = fault |
| short_det | input | 1 | Raw output short-circuit flag, 1 = fault |
| ss_done | input | 1 | Soft-start ramp finished, synchronous to clk |
| drv_off | output | 1 | 1 = both gate drivers forced off |
| ss_clamp | output | 1 | 1 = discharge soft-start and clamp compensation low |
| ready | output | 1 | 1 = regulating with no fault pending |

## Verification
The contested cycle is the one in which the hiccup delay expires while a fault flag changes. The most telling case is an over-temperature flag that is still set at one expiry and clears before the next. Another is a short circuit that persists through an expiry and re-trips during the new soft-start. A third is an over-temperature flag that arrives partway through a short-circuit delay. Each case is provoked by placing the raw flag change a known number of edges from delay entry. The result is judged by `drv_off` and `ready` on the edges on either side of the expiry.

// File: rtl/hrs_pkg.sv
// Package: shared types for the hiccup restart sequencer.
// Assumes: fault classes are ordered by restart priority.
package hrs_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_UV = 3'd0,   // idle, waiting for undervoltage removal
        ST_HIC_SC  = 3'd1,   // idle, short-circuit hiccup delay
        ST_HIC_OT  = 3'd2,   // idle, thermal hiccup delay (recycling)
        ST_SOFT    = 3'd3,   // soft-start ramp from zero
        ST_RUN     = 3'd4    // regulating
    } seq_state_t;

    typedef enum logic [1:0] {
        FC_NONE = 2'd0,
        FC_SC   = 2'd1,
        FC_OT   = 2'd2,
        FC_UV   = 2'd3
    } fault_class_t;

    // Idle state to enter for a newly seen fault class.
    function automatic seq_state_t fault_target(input fault_class_t cls,
                                                input seq_state_t  dflt);
        case (cls)
            FC_UV:   return ST_WAIT_UV;
            FC_OT:   return ST_HIC_OT;
            FC_SC:   return ST_HIC_SC;
            default: return dflt;
        endcase
    endfunction

endpackage

// File: rtl/hrs_flag_sync.sv
// Module: two-stage synchroniser for a vector of asynchronous fault flags.
// Assumes: each bit is independent; RESET_VAL gives the value both stages
// take in reset, so a fail-safe flag can start out "faulted".
module hrs_flag_sync #(
    parameter int                 WIDTH     = 4,
    parameter logic [WIDTH-1:0]   RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  raw_i,
    output logic [WIDTH-1:0]  sync_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta_q;
        logic stab_q;

        // Two flops per flag; reset to the bit's fail-safe value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RESET_VAL[i];
                stab_q <= RESET_VAL[i];
            end else begin
                meta_q <= raw_i[i];
                stab_q <= meta_q;
            end
        end

        assign sync_o[i] = stab_q;
    end

endmodule

// File: rtl/hrs_fault_arb.sv
// Module: folds synchronised flags into one fault class by priority.
// Assumes: flag vector layout is [NUM_UV-1:0] undervoltage sources,
// then over-temperature at NUM_UV, then short circuit at NUM_UV+1.
module hrs_fault_arb
    import hrs_pkg::*;
#(
    parameter int NUM_UV = 2,
    localparam int NFLAG = NUM_UV + 2,
    localparam int OT_IX = NUM_UV,
    localparam int SC_IX = NUM_UV + 1
) (
    input  logic [NFLAG-1:0] flags_i,
    output fault_class_t     cls_o,
    output logic             any_o
);

    logic [NUM_UV:0] uv_chain;

    assign uv_chain[0] = 1'b0;
    for (genvar u = 0; u < NUM_UV; u++) begin : g_uv
        assign uv_chain[u+1] = uv_chain[u] | flags_i[u];
    end

    // Priority pick: undervoltage, then thermal, then short circuit.
    always_comb begin
        if (uv_chain[NUM_UV])     cls_o = FC_UV;
        else if (flags_i[OT_IX])  cls_o = FC_OT;
        else if (flags_i[SC_IX])  cls_o = FC_SC;
        else                      cls_o = FC_NONE;
    end

    assign any_o = |flags_i;

endmodule

// File: rtl/hrs_hiccup_timer.sv
// Module: hiccup delay counter driven by an external timebase tick.
// Assumes: run stays high for the whole delay; clear restarts from zero;
// on expiry the count wraps so a held run re-times the next period.
module hrs_hiccup_timer #(
    parameter int  TICKS = 200,
    localparam int CW    = (TICKS > 1) ? $clog2(TICKS) : 1,
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clear_i,
    input  logic tick_i,
    output logic expire_o
);

    logic [CW-1:0] cnt_q;

    // Count ticks while running; reload to zero on clear, idle or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
        end
    end

    assign expire_o = run_i && tick_i && (cnt_q == LAST);

    a_r10_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i && !clear_i) |=> $stable(cnt_q));

    a_r6_wrap_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> (cnt_q == '0));

endmodule

// File: rtl/hiccup_restart_seq.sv
// Module: top of the hiccup fault restart sequencer. Synchronises the
// four fault flags, ranks them, and runs the idle/soft-start/run machine
// with a per-class restart policy.
// Assumes: ss_done is already synchronous to clk; fault gating of the
// outputs is combinational from the synchronised flags.
module hiccup_restart_seq
    import hrs_pkg::*;
#(
    parameter int HICCUP_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic uv_bias,
    input  logic uv_input,
    input  logic over_temp,
    input  logic short_det,
    input  logic ss_done,
    output logic drv_off,
    output logic ss_clamp,
    output logic ready
);

    localparam int NUM_UV = 2;
    localparam int NFLAG  = NUM_UV + 2;
    // Undervoltage stages start faulted; thermal and short start clear.
    localparam logic [NFLAG-1:0] SYNC_RST = {2'b00, {NUM_UV{1'b1}}};

    logic [NFLAG-1:0] flags_raw;
    logic [NFLAG-1:0] flags_s;
    fault_class_t     cls;
    logic             any_flt;
    logic             hic_expire;
    logic             hic_run;
    logic             hic_clear;
    seq_state_t       state_q;
    seq_state_t       state_d;
    logic             idle;

    assign flags_raw = {short_det, over_temp, uv_input, uv_bias};

    hrs_flag_sync #(
        .WIDTH     (NFLAG),
        .RESET_VAL (SYNC_RST)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (flags_raw),
        .sync_o (flags_s)
    );

    hrs_fault_arb #(
        .NUM_UV (NUM_UV)
    ) u_arb (
        .flags_i (flags_s),
        .cls_o   (cls),
        .any_o   (any_flt)
    );

    hrs_hiccup_timer #(
        .TICKS (HICCUP_TICKS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (hic_run),
        .clear_i  (hic_clear),
        .tick_i   (tick),
        .expire_o (hic_expire)
    );

    // Next-state selection with per-class restart policy.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_SOFT: begin
                state_d = fault_target(cls, ss_done ? ST_RUN : ST_SOFT);
            end
            ST_RUN: begin
                state_d = fault_target(cls, ST_RUN);
            end
            ST_WAIT_UV: begin
                state_d = fault_target(cls, ST_SOFT);
            end
            ST_HIC_SC: begin
                if (cls == FC_UV || cls == FC_OT)
                    state_d = fault_target(cls, ST_HIC_SC);
                else if (hic_expire)
                    state_d = ST_SOFT;
            end
            ST_HIC_OT: begin
                if (cls == FC_UV)
                    state_d = ST_WAIT_UV;
                else if (hic_expire && cls != FC_OT)
                    state_d = ST_SOFT;
            end
            default: state_d = ST_WAIT_UV;
        endcase
    end

    // State register; reset parks the machine idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT_UV;
        else        state_q <= state_d;
    end

    // Timer runs in either hiccup state and restarts on any state change.
    assign hic_run   = (state_q == ST_HIC_SC) || (state_q == ST_HIC_OT);
    assign hic_clear = (state_d != state_q);

    // Output gating: idle states or any visible fault force the stage off.
    assign idle     = (state_q == ST_WAIT_UV) || hic_run;
    assign drv_off  = idle || any_flt;
    assign ss_clamp = idle || any_flt;
    assign ready    = (state_q == ST_RUN) && !any_flt;

    a_r3_fault_leaves_active: assert property (@(posedge clk) disable iff (!rst_n)
        (any_flt && (state_q == ST_RUN || state_q == ST_SOFT))
        |=> (state_q != ST_RUN && state_q != ST_SOFT));

    a_r4_uv_release_no_timer: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_UV && cls == FC_NONE) |=> (state_q == ST_SOFT));

    a_r5_sc_waits_for_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIC_SC && !hic_expire) |=> (state_q != ST_SOFT));

    a_r6_ot_waits_for_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIC_OT && !hic_expire)
        |=> (state_q == ST_HIC_OT || state_q == ST_WAIT_UV));

    a_r7_uv_dominates: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == FC_UV) |=> (state_q == ST_WAIT_UV));

    a_r9_run_via_softstart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> ($past(state_q) == ST_RUN || $past(state_q) == ST_SOFT));

    a_r11_ot_preempts_sc: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIC_SC && cls == FC_OT) |=> (state_q == ST_HIC_OT));

endmodule

// File: tb/hiccup_restart_seq_test.sv
`timescale 1ns/1ps
module hiccup_restart_seq_test;

    localparam int TICKS = 5;
    localparam int NROW  = 43;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic uv_bias = 1'b0, uv_input = 1'b0, over_temp = 1'b0, short_det = 1'b0;
    logic ss_done = 1'b0;
    logic drv_off, ss_clamp, ready;
    int   checks = 0;
    int   fails  = 0;

    always #4 clk = ~clk;

    hiccup_restart_seq #(.HICCUP_TICKS(TICKS)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .uv_bias(uv_bias), .uv_input(uv_input),
        .over_temp(over_temp), .short_det(short_det),
        .ss_done(ss_done),
        .drv_off(drv_off), .ss_clamp(ss_clamp), .ready(ready)
    );

    // Row: flags {uvb,uvi,ot,sc}, ss_done, tick, edges, expected {drv,clamp,ready}, req.
    function automatic logic [20:0] row(input logic [3:0] f, input logic sd,
                                        input logic tk, input int cyc,
                                        input logic [2:0] ex, input int rq);
        return {f, sd, tk, 8'(cyc), ex, 4'(rq)};
    endfunction

    localparam logic [20:0] VEC [NROW] = '{
        row(4'b0000,1'b0,1'b1, 3,3'b000, 1),   // R1 start-up into soft-start
        row(4'b0000,1'b1,1'b1, 1,3'b001, 9),   // R9 ready after ss_done
        row(4'b0001,1'b1,1'b1, 2,3'b110, 3),   // R3 same-cycle gating
        row(4'b0000,1'b1,1'b1, 1,3'b110, 5),   // R5 hiccup entered
        row(4'b0000,1'b1,1'b1, 4,3'b110, 5),   // R5 delay not yet over
        row(4'b0000,1'b1,1'b1, 1,3'b000, 9),   // R9 restart via soft-start
        row(4'b0000,1'b1,1'b1, 1,3'b001, 9),
        row(4'b0001,1'b1,1'b1, 3,3'b110, 5),   // R5 persistent short
        row(4'b0001,1'b1,1'b1, 5,3'b110, 5),   // R5 retry while short present
        row(4'b0001,1'b1,1'b1, 1,3'b110, 5),
        row(4'b0000,1'b1,1'b1, 5,3'b000, 5),   // R5 second retry succeeds
        row(4'b0000,1'b1,1'b1, 1,3'b001, 9),
        row(4'b0010,1'b1,1'b1, 3,3'b110, 6),   // R6 thermal hiccup
        row(4'b0010,1'b1,1'b1, 5,3'b110, 6),   // R6 expiry with flag set: reload
        row(4'b0000,1'b1,1'b1, 4,3'b110, 6),   // R6 cleared but no expiry yet
        row(4'b0000,1'b1,1'b1, 1,3'b000, 6),   // R6 restart at next expiry
        row(4'b0000,1'b1,1'b1, 1,3'b001, 9),
        row(4'b0100,1'b1,1'b1, 3,3'b110, 4),   // R4 input undervoltage
        row(4'b0100,1'b1,1'b1,20,3'b110, 4),   // R4 held idle, no timeout
        row(4'b0000,1'b1,1'b1, 3,3'b000, 4),   // R4 restart on removal
        row(4'b0000,1'b1,1'b1, 1,3'b001, 4),
        row(4'b1000,1'b1,1'b1, 2,3'b110, 2),   // R2 two-edge latency
        row(4'b0000,1'b1,1'b1, 4,3'b001, 4),
        row(4'b0111,1'b1,1'b1, 3,3'b110, 7),   // R7 three faults together
        row(4'b0011,1'b1,1'b1, 3,3'b110, 7),   // R7 thermal over short
        row(4'b0010,1'b1,1'b1, 5,3'b110, 7),   // R7 thermal rule applied
        row(4'b0000,1'b1,1'b1, 5,3'b000, 7),
        row(4'b0000,1'b1,1'b1, 1,3'b001, 9),
        row(4'b0001,1'b1,1'b0, 3,3'b110,10),   // R10 no ticks
        row(4'b0000,1'b1,1'b0,20,3'b110,10),   // R10 delay frozen
        row(4'b0000,1'b1,1'b1, 5,3'b000,10),   // R10 ticks resume
        row(4'b0000,1'b1,1'b1, 1,3'b001, 9),
        row(4'b0001,1'b0,1'b1, 3,3'b110, 8),   // R8 short, ramp not done
        row(4'b0000,1'b0,1'b1, 5,3'b000, 8),   // R8 in soft-start
        row(4'b0001,1'b0,1'b1, 2,3'b110, 8),   // R8 short during soft-start
        row(4'b0000,1'b1,1'b1, 1,3'b110, 8),
        row(4'b0000,1'b1,1'b1, 5,3'b000, 8),
        row(4'b0000,1'b1,1'b1, 1,3'b001, 9),
        row(4'b0001,1'b1,1'b1, 3,3'b110,11),   // R11 short hiccup
        row(4'b0010,1'b1,1'b1, 3,3'b110,11),   // R11 thermal arrives
        row(4'b0000,1'b1,1'b1, 4,3'b110,11),   // R11 timer restarted
        row(4'b0000,1'b1,1'b1, 1,3'b000,11),
        row(4'b0000,1'b1,1'b1, 1,3'b001,11)
    };

    task automatic check(input logic [2:0] act, input logic [2:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s {drv_off,ss_clamp,ready} got %b expected %b at %0t",
                     req, act, exp, $time);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [20:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({drv_off, ss_clamp, ready}, 3'b110, "R1");   // R1 in reset
        rst_n = 1'b1;
        check({drv_off, ss_clamp, ready}, 3'b110, "R1");   // R1 just released

        for (int i = 0; i < NROW; i++) begin
            v = VEC[i];
            {uv_bias, uv_input, over_temp, short_det} = v[20:17];
            ss_done = v[16];
            tick    = v[15];
            repeat (int'(v[14:7])) @(posedge clk);
            @(negedge clk);
            check({drv_off, ss_clamp, ready}, v[6:4], $sformatf("R%0d row %0d", v[3:0], i));
        end

        // R1: synchronous reset from regulation forces idle after one edge.
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check({drv_off, ss_clamp, ready}, 3'b110, "R1");
        // R4: release with bias undervoltage held keeps the block idle.
        uv_bias = 1'b1;
        rst_n   = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        check({drv_off, ss_clamp, ready}, 3'b110, "R4");
        uv_bias = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check({drv_off, ss_clamp, ready}, 3'b001, "R4");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule